// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit turns a two-part logical address, made of a segment number and an offset inside that segment, into a physical address. It looks the segment up in a small on-chip segment table. Each table entry stores a physical base, a length limit, a valid flag and three permission flags (read, write, execute). One request is accepted per cycle. The response comes back one cycle later and carries one of two results: the translated address, or a trap code that names the first check that failed.

Four checks run in a fixed priority order:
1. The segment number must be below the programmed table length.
2. The entry must be marked valid.
3. The offset must be below the entry's limit.
4. The entry must allow the requested kind of access.

Software fills the table through a one-entry-per-cycle write port. It programs the table length through a separate write strobe.

The response side is driven by a two-state machine:
- `ST_IDLE` means no response is presented. It moves to `ST_RESP` when a request arrives, and stays in `ST_IDLE` otherwise.
- `ST_RESP` presents the result of the previous cycle's request. It stays in `ST_RESP` if another request arrives in the same cycle, and returns to `ST_IDLE` otherwise.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `rsp_valid` is 0, every table entry is invalid and the table length is 0, so any lookup returns cause 1.
- R2: A lookup whose segment number is greater than or equal to the table length returns cause 1. This check outranks all others.
- R3: A lookup of an in-range segment whose entry valid flag is 0 returns cause 2.
- R4: A lookup of a valid entry whose offset is greater than or equal to the entry limit returns cause 3. A limit of 0 rejects every offset.
- R5: The access code selects the required permission bit: 0 means read and needs perm bit 0, 1 means write and needs perm bit 1, 2 means execute and needs perm bit 2. Code 3 is never permitted. A missing permission returns cause 4.
- R6: When all checks pass, the cause is 0 and `rsp_paddr` equals base plus offset, modulo 2^24.
- R7: Whenever the cause is not 0, `rsp_paddr` is 0.
- R8: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` high, and 0 in every other cycle.
- R9: A table-entry write or a length write in the same cycle as a lookup is not seen by that lookup. It is seen by every lookup in later cycles.
- R10: When several checks would fail, the reported cause is the lowest-numbered one, in the order R2, R3, R4, R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset inside the segment |
| req_acc | input | 2 | Access code (0 read, 1 write, 2 execute, 3 reserved) |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 24 | Physical address, 0 on trap |
| rsp_cause | output | 3 | 0 ok, 1 segment range, 2 invalid, 3 limit, 4 permission |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 4 | Entry to write |
| tbl_base | input | 24 | Base to store |
| tbl_limit | input | 16 | Limit to store |
| tbl_vld | input | 1 | Valid flag to store |
| tbl_perm | input | 3 | Permissions to store: bit0 read, bit1 write, bit2 execute |
| len_we | input | 1 | Table length write strobe |
| len_value | input | 5 | New table length (0 to 31) |

## Verification
A lookup and a table update can land in the same cycle, whether the update is an entry write or a length write. The bench provokes this in two ways. First, it invalidates the entry being looked up in that very cycle. Second, it shrinks the table length below the segment being looked up in that cycle. The bench model takes its verdict from the table as it stood before the edge, then applies the write, so the first lookup must still succeed and the next one must trap. Random traffic with frequent writes to the same few entries then repeats the collision many times.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [2:0] {
        CAUSE_OK      = 3'd0,
        CAUSE_SEGNUM  = 3'd1,
        CAUSE_INVALID = 3'd2,
        CAUSE_LIMIT   = 3'd3,
        CAUSE_PERM    = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    localparam int PERM_W = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W  = 4,
    parameter int BASE_W = 24,
    parameter int LIM_W  = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [SEG_W-1:0]                    wr_idx,
    input  logic [BASE_W-1:0]                   wr_base,
    input  logic [LIM_W-1:0]                    wr_limit,
    input  logic                                wr_vld,
    input  logic [seg_xlate_pkg::PERM_W-1:0]    wr_perm,
    input  logic [SEG_W-1:0]                    rd_idx,
    output logic [BASE_W-1:0]                   rd_base,
    output logic [LIM_W-1:0]                    rd_limit,
    output logic                                rd_vld,
    output logic [seg_xlate_pkg::PERM_W-1:0]    rd_perm
);
    localparam int NSEG = 2 ** SEG_W;

    logic [BASE_W-1:0]                base_q  [NSEG];
    logic [LIM_W-1:0]                 lim_q   [NSEG];
    logic [NSEG-1:0]                  vld_q;
    logic [seg_xlate_pkg::PERM_W-1:0] perm_q  [NSEG];

    for (genvar i = 0; i < NSEG; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                lim_q[i]  <= '0;
                vld_q[i]  <= 1'b0;
                perm_q[i] <= '0;
            end else if (we && (wr_idx == SEG_W'(i))) begin
                base_q[i] <= wr_base;
                lim_q[i]  <= wr_limit;
                vld_q[i]  <= wr_vld;
                perm_q[i] <= wr_perm;
            end
        end

        // R9: a write lands in the addressed entry on the following cycle
        a_r9_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
            (we && wr_idx == SEG_W'(i)) |=>
                (base_q[i] == $past(wr_base) && lim_q[i] == $past(wr_limit) &&
                 vld_q[i] == $past(wr_vld)));
    end

    always_comb begin
        rd_base  = base_q[rd_idx];
        rd_limit = lim_q[rd_idx];
        rd_vld   = vld_q[rd_idx];
        rd_perm  = perm_q[rd_idx];
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int OFF_W  = 16,
    parameter int BASE_W = 24,
    parameter int LIM_W  = 16
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        acc,
    input  logic [SEG_W:0]    tbl_len,
    input  logic [BASE_W-1:0] ent_base,
    input  logic [LIM_W-1:0]  ent_limit,
    input  logic              ent_vld,
    input  logic [PERM_W-1:0] ent_perm,
    output cause_e            cause,
    output logic [BASE_W-1:0] paddr
);
    localparam int CMP_W = (OFF_W > LIM_W) ? OFF_W : LIM_W;
    localparam int SUM_W = (OFF_W > BASE_W) ? OFF_W : BASE_W;

    logic             seg_in_range;
    logic             off_in_limit;
    logic             perm_ok;
    logic [SUM_W-1:0] sum;

    always_comb begin
        seg_in_range = {1'b0, seg} < tbl_len;
        off_in_limit = CMP_W'(off) < CMP_W'(ent_limit);
        unique case (acc_e'(acc))
            ACC_READ:  perm_ok = ent_perm[0];
            ACC_WRITE: perm_ok = ent_perm[1];
            ACC_EXEC:  perm_ok = ent_perm[2];
            ACC_RSVD:  perm_ok = 1'b0;
            default:   perm_ok = 1'b0;
        endcase
        sum = SUM_W'(ent_base) + SUM_W'(off);

        // fixed priority: range, valid, limit, permission
        if (!seg_in_range)      cause = CAUSE_SEGNUM;
        else if (!ent_vld)      cause = CAUSE_INVALID;
        else if (!off_in_limit) cause = CAUSE_LIMIT;
        else if (!perm_ok)      cause = CAUSE_PERM;
        else                    cause = CAUSE_OK;

        paddr = (cause == CAUSE_OK) ? sum[BASE_W-1:0] : '0;
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int OFF_W  = 16,
    parameter int BASE_W = 24,
    parameter int LIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              rsp_valid,
    output logic [BASE_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_cause,
    input  logic              tbl_we,
    input  logic [SEG_W-1:0]  tbl_idx,
    input  logic [BASE_W-1:0] tbl_base,
    input  logic [LIM_W-1:0]  tbl_limit,
    input  logic              tbl_vld,
    input  logic [PERM_W-1:0] tbl_perm,
    input  logic              len_we,
    input  logic [SEG_W:0]    len_value
);
    localparam int LEN_W = SEG_W + 1;

    rsp_state_e        state_q, state_d;
    logic [LEN_W-1:0]  len_q;
    logic [BASE_W-1:0] ent_base;
    logic [LIM_W-1:0]  ent_limit;
    logic              ent_vld;
    logic [PERM_W-1:0] ent_perm;
    cause_e            chk_cause;
    logic [BASE_W-1:0] chk_paddr;
    cause_e            cause_q;
    logic [BASE_W-1:0] paddr_q;

    seg_table #(.SEG_W(SEG_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_base  (tbl_base),
        .wr_limit (tbl_limit),
        .wr_vld   (tbl_vld),
        .wr_perm  (tbl_perm),
        .rd_idx   (req_seg),
        .rd_base  (ent_base),
        .rd_limit (ent_limit),
        .rd_vld   (ent_vld),
        .rd_perm  (ent_perm)
    );

    seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_check (
        .seg       (req_seg),
        .off       (req_off),
        .acc       (req_acc),
        .tbl_len   (len_q),
        .ent_base  (ent_base),
        .ent_limit (ent_limit),
        .ent_vld   (ent_vld),
        .ent_perm  (ent_perm),
        .cause     (chk_cause),
        .paddr     (chk_paddr)
    );

    // length register: a write becomes visible to the next cycle's lookups
    always_ff @(posedge clk) begin
        if (!rst_n)      len_q <= '0;
        else if (len_we) len_q <= len_value;
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_OK;
            paddr_q <= '0;
        end else if (req_valid) begin
            cause_q <= chk_cause;
            paddr_q <= chk_paddr;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_cause = cause_q;
                rsp_paddr = paddr_q;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_cause = CAUSE_OK;
                rsp_paddr = '0;
            end
        endcase
    end

    // R8: each request gives a response on the next cycle
    a_r8_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8: no request means no response on the next cycle
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2: an out-of-range segment number traps with cause 1
    a_r2_seg_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= len_q)) |=> (rsp_cause == 3'd1));

    // R7: a trap never carries an address
    a_r7_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause != 3'd0) |-> (rsp_paddr == '0));

    // R1: the first response after reset is a segment-range trap
    a_r1_len_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (len_q == '0));

endmodule

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic [2:0]  rsp_cause;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_idx = '0;
    logic [23:0] tbl_base = '0;
    logic [15:0] tbl_limit = '0;
    logic        tbl_vld = 1'b0;
    logic [2:0]  tbl_perm = '0;
    logic        len_we = 1'b0;
    logic [4:0]  len_value = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string note = "";

    // reference model state
    int m_base [16];
    int m_lim  [16];
    int m_vld  [16];
    int m_perm [16];
    int m_len;
    int exp_v;
    int exp_c;
    int exp_pa;
    string exp_note;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate_unit u_seg_xlate_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
        .tbl_vld(tbl_vld), .tbl_perm(tbl_perm),
        .len_we(len_we), .len_value(len_value)
    );

    function automatic string cause_tag(int c);
        case (c)
            0: return "R6";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    // model: verdict from the pre-edge table, then apply writes (R9)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_base[i] = 0; m_lim[i] = 0; m_vld[i] = 0; m_perm[i] = 0;
            end
            m_len = 0;
            exp_v = 0;
        end else begin
            exp_v = req_valid ? 1 : 0;
            exp_note = note;
            if (req_valid) begin
                int s, o, a;
                s = int'(req_seg); o = int'(req_off); a = int'(req_acc);
                if (s >= m_len)                            exp_c = 1;
                else if (m_vld[s] == 0)                    exp_c = 2;
                else if (o >= m_lim[s])                    exp_c = 3;
                else if (a == 3 || ((m_perm[s] >> a) & 1) == 0) exp_c = 4;
                else                                       exp_c = 0;
                exp_pa = (exp_c == 0) ? ((m_base[s] + o) & 32'hFFFFFF) : 0;
            end
            if (tbl_we) begin
                m_base[tbl_idx] = int'(tbl_base);
                m_lim[tbl_idx]  = int'(tbl_limit);
                m_vld[tbl_idx]  = int'(tbl_vld);
                m_perm[tbl_idx] = int'(tbl_perm);
            end
            if (len_we) m_len = int'(len_value);
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (int'(rsp_valid) != exp_v) begin
                errors++;
                $display("FAIL R8 %s rsp_valid actual %0d expected %0d", exp_note, rsp_valid, exp_v);
            end
            if (exp_v == 1) begin
                checks++;
                if (int'(rsp_cause) != exp_c) begin
                    errors++;
                    $display("FAIL %s R10 %s cause actual %0d expected %0d",
                             cause_tag(exp_c), exp_note, rsp_cause, exp_c);
                end
                checks++;
                if (int'(rsp_paddr) != exp_pa) begin
                    errors++;
                    $display("FAIL %s %s paddr actual %h expected %h",
                             (exp_c == 0) ? "R6" : "R7", exp_note, rsp_paddr, exp_pa);
                end
            end
        end
    end

    task automatic idle_all();
        req_valid = 0; tbl_we = 0; len_we = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle_all();
    endtask

    task automatic lookup(input int s, input int o, input int a);
        req_valid = 1; req_seg = 4'(s); req_off = 16'(o); req_acc = 2'(a);
        tick();
    endtask

    task automatic put_entry(input int i, input int b, input int l, input int v, input int p);
        tbl_we = 1; tbl_idx = 4'(i); tbl_base = 24'(b); tbl_limit = 16'(l);
        tbl_vld = 1'(v); tbl_perm = 3'(p);
        tick();
    endtask

    task automatic put_len(input int n);
        len_we = 1; len_value = 5'(n);
        tick();
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state visible at the ports
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 rsp_valid in reset actual %0d expected 0", rsp_valid);
        end
        rst_n = 1;
        note = "R1"; lookup(0, 0, 0);           // R1: length 0 -> cause 1
        tick();
        note = "";
        put_len(8);
        put_entry(2, 24'h100000, 16'h0100, 1, 3'b001);
        lookup(2, 16'h0010, 0);                  // R6 ok
        lookup(9, 0, 0);                         // R2
        lookup(8, 0, 0);                         // R2 boundary
        lookup(3, 0, 0);                         // R3
        lookup(2, 16'h0100, 0);                  // R4 boundary
        lookup(2, 16'h00FF, 0);                  // R6 top offset
        lookup(2, 0, 1);                         // R5 write denied
        lookup(2, 0, 3);                         // R5 reserved code
        put_entry(6, 24'h000200, 0, 1, 3'b111);
        lookup(6, 0, 0);                         // R4 zero limit
        note = "R10";
        lookup(3, 16'hFFFF, 3);                  // invalid outranks limit and perm
        lookup(2, 16'h0200, 1);                  // limit outranks perm
        lookup(12, 0, 0);                        // range outranks everything
        note = "";
        put_entry(5, 24'hFFFFF0, 16'h0100, 1, 3'b110);
        lookup(5, 16'h0020, 2);                  // R6 wrap
        lookup(5, 16'h0020, 1);                  // R6 write allowed
        lookup(5, 16'h0020, 0);                  // R5 read denied
        // R9: entry write in same cycle as lookup of that entry
        note = "R9";
        req_valid = 1; req_seg = 2; req_off = 1; req_acc = 0;
        tbl_we = 1; tbl_idx = 2; tbl_base = 24'h100000; tbl_limit = 16'h0100;
        tbl_vld = 0; tbl_perm = 3'b001;
        tick();
        lookup(2, 1, 0);
        // R9: length write in same cycle as lookup
        req_valid = 1; req_seg = 5; req_off = 0; req_acc = 1;
        len_we = 1; len_value = 2;
        tick();
        lookup(5, 0, 1);
        note = "";
        tick(); tick();                          // R8 idle gaps
        put_len(16);
        // random traffic
        for (int k = 0; k < 600; k++) begin
            req_valid = 1'($urandom_range(0, 3) != 0);
            req_seg = 4'($urandom_range(0, 15));
            req_off = 16'($urandom_range(0, 600));
            req_acc = 2'($urandom_range(0, 3));
            tbl_we = 1'($urandom_range(0, 2) == 0);
            tbl_idx = 4'($urandom_range(0, 15));
            tbl_base = 24'($urandom);
            tbl_limit = 16'($urandom_range(0, 600));
            tbl_vld = 1'($urandom_range(0, 4) != 0);
            tbl_perm = 3'($urandom_range(0, 7));
            len_we = 1'($urandom_range(0, 30) == 0);
            len_value = 5'($urandom_range(4, 17));
            tick();
        end
        tick(); tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule